// File: doc/BRIEF.md
# Sound Generator Command/Data Port Bridge

This block sits between an 8-bit processor bus and a sound generator that exposes one address port and one data port. The processor first writes an access mode into a command register. Every later access to the data register is then decoded through that mode. Depending on the mode, the access latches a register address, writes a byte into the generator, reads a byte back, reads a status byte or reads a joystick byte.

The generator's register file is modelled as a 16-entry by 8-bit array, so the bridge can be checked on its own. Tone synthesis is not part of the block.

A parameter selects between two variants. The basic variant keeps a 2-bit mode. The extended variant keeps 4 command bits and adds a status read and a joystick read. These two reads take priority over the 2-bit mode. All bus reads are combinational in the cycle of the access. Writes take effect at the rising clock edge of the access cycle.

Top module: `snd_bridge`

## Requirements
- R1: After reset the command register is 0 (idle), the address latch is 0, and every entry of the register array is 0x00.
- R2: In the basic variant (EXTENDED=0) the command register keeps only bits 1..0 of a command write. A command read returns those bits with bits 7..2 forced to 1.
- R3: In the extended variant (EXTENDED=1) the command register keeps bits 3..0. A command read returns them with bits 7..4 forced to 1.
- R4: In mode 0 (command bits 1..0 = 0), a data write changes nothing and a data read returns 0xFF.
- R5: In mode 1, a data read returns the register array entry at the latched address.
- R6: In mode 2, a data write stores the byte at the latched address. A data read in mode 2 returns 0xFF, because it is a write conflict.
- R7: In mode 3, a data write latches bits 3..0 of the byte as the register address and ignores bits 7..4. A data read in mode 3 returns the entry at the latched address.
- R8: In the extended variant, while command bit 3 is set, a data read returns the joy_in input as sampled in that cycle. This holds whatever the values of bit 2 and bits 1..0.
- R9: In the extended variant, while command bit 3 is clear and bit 2 is set, a data read returns the status_in input as sampled in that cycle.
- R10: In the extended variant, a data write while command bit 2 or bit 3 is set neither stores a byte nor changes the address latch.
- R11: In the basic variant, bits 3..2 of a command write are dropped, so the status and joystick reads are never selected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_cs | input | 1 | Bus access strobe for this cycle |
| bus_we | input | 1 | 1 = write access, 0 = read access |
| bus_port | input | 1 | 0 = command register, 1 = data register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of a read access |
| status_in | input | 8 | Status byte from the generator |
| joy_in | input | 8 | Joystick byte |

## Verification
The hardest effect to observe is a data write that must be dropped, either in idle mode or under a status or joystick mode. It has no visible effect at the moment it happens. The bench therefore switches to mode 1 afterwards and reads back the addressed entry, and it also re-latches a known address to prove that the latch did not move. Both variants are instantiated on the same bus, so a single command byte with bits 3..2 set puts the extended instance in a priority mode while the basic instance treats it as a plain 2-bit mode. The same data write can then be seen to land in one instance and be dropped in the other.

// File: rtl/snd_bridge_pkg.sv
package snd_bridge_pkg;

    // Action produced for one bus cycle
    typedef enum logic [3:0] {
        ACT_NONE,
        ACT_WR_CMD,
        ACT_RD_CMD,
        ACT_LATCH_ADDR,
        ACT_WR_REG,
        ACT_RD_REG,
        ACT_RD_FF,
        ACT_RD_STAT,
        ACT_RD_JOY
    } action_e;

    localparam int CMD_FULL_W = 4;

endpackage

// File: rtl/snd_bridge_decode.sv
module snd_bridge_decode
    import snd_bridge_pkg::*;
#(
    parameter bit EXTENDED = 1'b1
) (
    input  logic [CMD_FULL_W-1:0] cmd,
    input  logic                  cs,
    input  logic                  we,
    input  logic                  port,
    output action_e               act
);

    always_comb begin
        act = ACT_NONE;
        if (cs) begin
            if (!port) begin
                act = we ? ACT_WR_CMD : ACT_RD_CMD;
            end else if (EXTENDED && cmd[3]) begin
                act = we ? ACT_NONE : ACT_RD_JOY;
            end else if (EXTENDED && cmd[2]) begin
                act = we ? ACT_NONE : ACT_RD_STAT;
            end else begin
                unique case (cmd[1:0])
                    2'd0: act = we ? ACT_NONE       : ACT_RD_FF;
                    2'd1: act = we ? ACT_NONE       : ACT_RD_REG;
                    2'd2: act = we ? ACT_WR_REG     : ACT_RD_FF;
                    2'd3: act = we ? ACT_LATCH_ADDR : ACT_RD_REG;
                    default: act = ACT_NONE;
                endcase
            end
        end
    end

endmodule

// File: rtl/snd_bridge_regfile.sv
module snd_bridge_regfile #(
    parameter int DW = 8,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_d [DEPTH];
    logic [DW-1:0] mem_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (wr_en) begin
            mem_d[addr] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= mem_d[i];
            end
        end
    end

    assign rd_data = mem_q[addr];

endmodule

// File: rtl/snd_bridge.sv
module snd_bridge
    import snd_bridge_pkg::*;
#(
    parameter bit EXTENDED = 1'b1,
    parameter int DW       = 8,
    parameter int AW       = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_cs,
    input  logic          bus_we,
    input  logic          bus_port,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic [DW-1:0] status_in,
    input  logic [DW-1:0] joy_in
);

    localparam int CMD_W = EXTENDED ? CMD_FULL_W : 2;

    typedef struct packed {
        logic [CMD_W-1:0] cmd;
        logic [AW-1:0]    addr;
    } state_t;

    state_t                st_d, st_q;
    action_e               act;
    logic [CMD_FULL_W-1:0] cmd_full;
    logic [DW-1:0]         reg_rd;
    logic                  reg_we;

    // Widen the stored command for the decoder
    generate
        if (CMD_W == CMD_FULL_W) begin : g_cmd_ext
            assign cmd_full = st_q.cmd;
        end else begin : g_cmd_basic
            assign cmd_full = {{(CMD_FULL_W-CMD_W){1'b0}}, st_q.cmd};
        end
    endgenerate

    snd_bridge_decode #(.EXTENDED(EXTENDED)) u_decode (
        .cmd  (cmd_full),
        .cs   (bus_cs),
        .we   (bus_we),
        .port (bus_port),
        .act  (act)
    );

    assign reg_we = (act == ACT_WR_REG);

    snd_bridge_regfile #(.DW(DW), .AW(AW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_we),
        .addr    (st_q.addr),
        .wr_data (bus_wdata),
        .rd_data (reg_rd)
    );

    always_comb begin
        st_d      = st_q;
        bus_rdata = '1;
        unique case (act)
            ACT_WR_CMD:     st_d.cmd  = bus_wdata[CMD_W-1:0];
            ACT_LATCH_ADDR: st_d.addr = bus_wdata[AW-1:0];
            ACT_RD_CMD:     bus_rdata[CMD_W-1:0] = st_q.cmd;
            ACT_RD_REG:     bus_rdata = reg_rd;
            ACT_RD_STAT:    bus_rdata = status_in;
            ACT_RD_JOY:     bus_rdata = joy_in;
            default:        bus_rdata = '1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/snd_bridge_chk.sv
module snd_bridge_chk #(
    parameter bit EXTENDED = 1'b1,
    parameter int DW       = 8,
    parameter int AW       = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_cs,
    input logic          bus_we,
    input logic          bus_port,
    input logic [DW-1:0] bus_wdata,
    input logic [DW-1:0] bus_rdata,
    input logic [DW-1:0] joy_in,
    input logic [3:0]    cmd_full,
    input logic [AW-1:0] addr_q,
    input logic          reg_we
);

    localparam int CMD_W = EXTENDED ? 4 : 2;

    logic rd_data_acc, wr_data_acc, prio;
    assign rd_data_acc = bus_cs && !bus_we && bus_port;
    assign wr_data_acc = bus_cs && bus_we && bus_port;
    assign prio        = EXTENDED && (cmd_full[3:2] != 2'b00);

    // R1
    a_r1_reset_idle: assert property (@(posedge clk)
        $rose(rst_n) |-> (cmd_full == 4'd0 && addr_q == '0));

    // R2 and R3
    a_r3_cmd_readback_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cs && !bus_we && !bus_port) |-> ((bus_rdata >> CMD_W) == ({DW{1'b1}} >> CMD_W)));

    a_r4_idle_read_ff: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data_acc && cmd_full == 4'd0) |-> (bus_rdata == {DW{1'b1}}));

    a_r6_store_only_in_mode2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> (wr_data_acc && cmd_full[1:0] == 2'd2 && !prio));

    a_r7_addr_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data_acc && cmd_full[1:0] == 2'd3 && !prio) |=> (addr_q == $past(bus_wdata[AW-1:0])));

    a_r8_joy_priority: assert property (@(posedge clk) disable iff (!rst_n)
        (EXTENDED && rd_data_acc && cmd_full[3]) |-> (bus_rdata == joy_in));

    a_r10_prio_write_holds_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data_acc && prio) |=> $stable(addr_q));

    a_r11_basic_no_prio_bits: assert property (@(posedge clk) disable iff (!rst_n)
        !EXTENDED |-> (cmd_full[3:2] == 2'b00));

endmodule

bind snd_bridge snd_bridge_chk #(.EXTENDED(EXTENDED), .DW(DW), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_cs    (bus_cs),
    .bus_we    (bus_we),
    .bus_port  (bus_port),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .joy_in    (joy_in),
    .cmd_full  (cmd_full),
    .addr_q    (st_q.addr),
    .reg_we    (reg_we)
);

// File: tb/snd_bridge_bench.sv
module snd_bridge_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_cs = 1'b0;
    logic       bus_we = 1'b0;
    logic       bus_port = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] status_in = 8'h00;
    logic [7:0] joy_in = 8'h00;
    logic [7:0] rd_ext, rd_bas;

    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;

    snd_bridge #(.EXTENDED(1'b1)) u_snd_bridge (
        .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_we(bus_we),
        .bus_port(bus_port), .bus_wdata(bus_wdata), .bus_rdata(rd_ext),
        .status_in(status_in), .joy_in(joy_in)
    );

    snd_bridge #(.EXTENDED(1'b0)) u_snd_bridge_basic (
        .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_we(bus_we),
        .bus_port(bus_port), .bus_wdata(bus_wdata), .bus_rdata(rd_bas),
        .status_in(status_in), .joy_in(joy_in)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    // One write cycle; commits at the rising edge inside it
    task automatic bus_write(input logic port, input logic [7:0] data);
        @(negedge clk);
        bus_cs = 1'b1; bus_we = 1'b1; bus_port = port; bus_wdata = data;
        @(negedge clk);
        bus_cs = 1'b0; bus_we = 1'b0;
    endtask

    // One read cycle; compare both instances while the access is held
    task automatic bus_read(input logic port, input string req,
                            input logic [7:0] exp_ext, input logic [7:0] exp_bas);
        @(negedge clk);
        bus_cs = 1'b1; bus_we = 1'b0; bus_port = port;
        #1;
        check({req, " ext"}, rd_ext, exp_ext);
        check({req, " basic"}, rd_bas, exp_bas);
        @(negedge clk);
        bus_cs = 1'b0;
    endtask

    task automatic t_reset;
        bus_read(1'b0, "R1 R3 R2 cmd after reset", 8'hF0, 8'hFC);
        bus_read(1'b1, "R4 idle read", 8'hFF, 8'hFF);
    endtask

    task automatic t_idle_write;
        bus_write(1'b1, 8'h55);              // R4 dropped in mode 0
        bus_write(1'b0, 8'h01);
        bus_read(1'b1, "R4 idle write dropped / R5", 8'h00, 8'h00);
    endtask

    task automatic t_latch_and_store;
        bus_write(1'b0, 8'h03);
        bus_write(1'b1, 8'h25);              // R7 address 5
        bus_write(1'b0, 8'h02);
        bus_write(1'b1, 8'hA7);
        bus_read(1'b1, "R6 write-mode read", 8'hFF, 8'hFF);
        bus_write(1'b0, 8'h01);
        bus_read(1'b1, "R5 R6 stored byte", 8'hA7, 8'hA7);
        bus_write(1'b0, 8'h03);
        bus_write(1'b1, 8'h13);              // R7 upper nibble ignored, address 3
        bus_write(1'b0, 8'h02);
        bus_write(1'b1, 8'h3C);
        bus_write(1'b0, 8'h03);
        bus_read(1'b1, "R7 mode-3 read", 8'h3C, 8'h3C);
    endtask

    task automatic t_priority_reads;
        status_in = 8'h81; joy_in = 8'h42;
        bus_write(1'b0, 8'h05);
        bus_read(1'b1, "R9 status / R11 basic mode 1", 8'h81, 8'h3C);
        bus_write(1'b0, 8'h0D);
        bus_read(1'b1, "R8 joystick / R11", 8'h42, 8'h3C);
        bus_read(1'b0, "R3 R2 cmd readback", 8'hFD, 8'hFD);
        joy_in = 8'h9E;
        bus_write(1'b0, 8'h0F);
        bus_read(1'b1, "R8 joystick over mode 3", 8'h9E, 8'h3C);
    endtask

    task automatic t_prio_write_dropped;
        bus_write(1'b0, 8'h06);
        bus_write(1'b1, 8'h99);              // ext dropped, basic stores at 3
        bus_write(1'b0, 8'h07);
        bus_write(1'b1, 8'h2A);              // ext dropped, basic address A
        bus_write(1'b0, 8'h01);
        bus_read(1'b1, "R10 ext write dropped / R7 basic", 8'h3C, 8'h00);
        bus_write(1'b0, 8'h03);
        bus_write(1'b1, 8'h03);
        bus_write(1'b0, 8'h01);
        bus_read(1'b1, "R10 ext unchanged / R6 basic stored", 8'h3C, 8'h99);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_idle_write();
        t_latch_and_store();
        t_priority_reads();
        t_prio_write_dropped();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule